// File: doc/BRIEF.md
# Interrupt Source Unit with Edge and Level Sources

This unit collects a fixed set of interrupt lines and turns them into priority-tagged offers for a downstream presentation stage. Each line is either edge-type or level-type, chosen per source by a build-time map. For every source the unit keeps a target server number, an 8-bit priority and a small set of status flags. A priority of 0xFF masks the source. An offer carries a global source number, formed as the local index plus a fixed base, together with the server and the priority.

The presentation stage answers with a reject, when it cannot take the offer, or with an end-of-interrupt once servicing is done. Both carry the global number. The unit reacts differently for the two source types. A resend strobe makes the unit reconsider every source that qualifies and queue it for a new offer.

Queued offers go into a request vector. Only one offer sits on the output at a time. It is held until the consumer takes it, and the lowest queued index goes next.

Top module: `intsrc_unit`

## Requirements
- R1: After reset every priority is 0xFF, all status flags and queued requests are clear, and no offer is presented. The per-source type is unchanged by reset: a level source stays level-type.
- R2: A rising edge on a masked edge-type source (priority 0xFF) produces no offer and records a masked-pending flag. A later configuration write to that source with a priority other than 0xFF clears the flag and queues an offer.
- R3: A rising edge on an unmasked edge-type source queues an offer. The offer has number BASE plus the local index, and carries the configured server and priority.
- R4: A level-type source is offered only when three things hold: its priority is not 0xFF, its line is high and its sent flag is clear. Offering it sets sent. The check runs on a rising line, on a configuration write to the source and on a resend.
- R5: A reject aimed at an edge source sets its rejected flag. A reject aimed at a level source clears its sent flag. Neither re-offers the source by itself.
- R6: On a resend strobe, each edge source with rejected set has the flag cleared, and is re-offered only if its priority is not 0xFF. Each level source gets the check of R4.
- R7: An end-of-interrupt aimed at a level source clears its sent flag without re-offering it. An end-of-interrupt aimed at an edge source changes nothing.
- R8: Reject and end-of-interrupt numbers map to the local index by subtracting BASE. A number below BASE, or at BASE plus the source count or above, is ignored. A presented offer number always lies within the unit's range.
- R9: At most one offer is presented. It stays unchanged while offer_ready is low. Queued requests are served lowest local index first, and an offer is loaded on the cycle after its request is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_SRC | Per-source interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | IDX_W | Local index being configured |
| cfg_server | input | SRV_W | New server number |
| cfg_prio | input | 8 | New priority, 0xFF masks |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Resend strobe |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | Consumer takes the offer this cycle |
| offer_num | output | NUM_W | Global source number of the offer |
| offer_server | output | SRV_W | Server of the offer |
| offer_prio | output | 8 | Priority of the offer |

## Verification
The assertions on stability and on the offer range assume that offer_ready is a clean level, and that the consumer drops its request only by taking the offer. The masked-pending invariant assumes that configuration writes reach the unit only through cfg_we, with one source per cycle. The bench drives every strobe as a single-cycle pulse, aimed at one source at a time. It never changes a priority while that source has an offer queued, so the priority carried by an offer is always the one configured when the request arose. Out-of-range numbers are chosen both below BASE and in the aliasing band above it.

// File: rtl/intsrc_unit.sv
module intsrc_unit #(
  parameter int N_SRC = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 12,
  parameter logic [NUM_W-1:0] BASE = 12'h010,
  parameter logic [N_SRC-1:0] LEVEL_MAP = 8'hF0,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_src,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  output logic             offer_valid,
  input  logic             offer_ready,
  output logic [NUM_W-1:0] offer_num,
  output logic [SRV_W-1:0] offer_server,
  output logic [7:0]       offer_prio
);
  localparam logic [7:0] MASKED = 8'hFF;
  localparam logic [NUM_W-1:0] SPAN = NUM_W'(N_SRC);

  logic [7:0]       prio_q [N_SRC];
  logic [SRV_W-1:0] srv_q  [N_SRC];
  logic [N_SRC-1:0] line_q, sent_q, rej_q, mpend_q, req_q;
  logic [N_SRC-1:0] sent_n, rej_n, mpend_n, req_set;
  logic [N_SRC-1:0] cfg_hit, rej_hit, eoi_hit;

  wire [NUM_W-1:0] rej_off = rej_num - BASE;
  wire [NUM_W-1:0] eoi_off = eoi_num - BASE;
  wire rej_in = rej_valid && rej_num >= BASE && rej_off < SPAN;
  wire eoi_in = eoi_valid && eoi_num >= BASE && eoi_off < SPAN;

  logic [IDX_W-1:0] pick;
  logic             found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_q[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  wire take = found && (!offer_valid || offer_ready);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign cfg_hit[g] = cfg_we && cfg_src == IDX_W'(g);
    assign rej_hit[g] = rej_in && rej_off == NUM_W'(g);
    assign eoi_hit[g] = eoi_in && eoi_off == NUM_W'(g);

    wire [7:0] pn  = cfg_hit[g] ? cfg_prio : prio_q[g];
    wire       open = pn != MASKED;
    wire       rise = irq_in[g] & ~line_q[g];

    if (LEVEL_MAP[g]) begin : g_lvl
      wire keep = sent_q[g] & ~rej_hit[g] & ~eoi_hit[g];
      wire fire = (cfg_hit[g] | rise | resend) & irq_in[g] & open & ~keep;
      assign req_set[g] = fire;
      assign sent_n[g]  = keep | fire;
      assign rej_n[g]   = 1'b0;
      assign mpend_n[g] = 1'b0;

      assert_sent_needs_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent_q[g]) |-> line_q[g]);
    end else begin : g_edge
      wire rtmp   = rej_q[g] | rej_hit[g];
      wire mp_clr = cfg_hit[g] & mpend_q[g] & open;
      assign req_set[g] = mp_clr | (rise & open) | (resend & rtmp & open);
      assign mpend_n[g] = (mpend_q[g] & ~mp_clr) | (rise & ~open);
      assign rej_n[g]   = rtmp & ~resend;
      assign sent_n[g]  = 1'b0;

      assert_pending_only_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mpend_q[g] |-> prio_q[g] == MASKED);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) begin
        prio_q[i] <= MASKED;
        srv_q[i]  <= '0;
      end
      line_q       <= '0;
      sent_q       <= '0;
      rej_q        <= '0;
      mpend_q      <= '0;
      req_q        <= '0;
      offer_valid  <= 1'b0;
      offer_num    <= '0;
      offer_server <= '0;
      offer_prio   <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (cfg_hit[i]) begin
          prio_q[i] <= cfg_prio;
          srv_q[i]  <= cfg_server;
        end
      end
      line_q  <= irq_in;
      sent_q  <= sent_n;
      rej_q   <= rej_n;
      mpend_q <= mpend_n;
      req_q   <= (req_q & ~(take ? (N_SRC'(1) << pick) : '0)) | req_set;
      if (offer_valid && offer_ready) offer_valid <= 1'b0;
      if (take) begin
        offer_valid  <= 1'b1;
        offer_num    <= BASE + NUM_W'(pick);
        offer_server <= srv_q[pick];
        offer_prio   <= prio_q[pick];
      end
    end
  end

  assert_offer_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_num >= BASE && offer_num - BASE < SPAN));

  assert_offer_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |=> offer_valid && $stable(offer_num) && $stable(offer_prio)
      && $stable(offer_server));
endmodule

// File: tb/intsrc_unit_tb_top.sv
module intsrc_unit_tb_top;
  localparam int N = 8;
  localparam int B = 16;
  localparam logic [7:0] LVL = 8'hF0;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic cfg_we = 0, rej_valid = 0, eoi_valid = 0, resend = 0, offer_ready = 0;
  logic [2:0] cfg_src = '0;
  logic [3:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0;
  logic [11:0] rej_num = '0, eoi_num = '0;
  logic offer_valid;
  logic [11:0] offer_num;
  logic [3:0] offer_server;
  logic [7:0] offer_prio;

  always #2 clk = ~clk;

  intsrc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend), .offer_valid(offer_valid),
    .offer_ready(offer_ready), .offer_num(offer_num), .offer_server(offer_server),
    .offer_prio(offer_prio));

  int nchk = 0, nfail = 0;
  string phase = "R1";
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  int  m_pri[N], m_srv[N];
  bit  m_line[N], m_sent[N], m_rej[N], m_mp[N], m_req[N];
  bit  m_ov;
  int  m_num, m_osrv, m_opri;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pri[i] = 255; m_srv[i] = 0;
        m_line[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_req[i] = 0;
      end
      m_ov = 0;
    end else begin
      bit free, got;
      free = !m_ov || offer_ready;
      if (m_ov && offer_ready) m_ov = 0;
      got = 0;
      if (free)
        for (int i = 0; i < N; i++)
          if (!got && m_req[i]) begin
            got = 1; m_req[i] = 0; m_ov = 1;
            m_num = B + i; m_osrv = m_srv[i]; m_opri = m_pri[i];
          end
      for (int i = 0; i < N; i++) begin
        bit c, rh, eh, rs;
        c  = cfg_we && cfg_src == i;
        rh = rej_valid && rej_num == B + i;
        eh = eoi_valid && eoi_num == B + i;
        rs = irq_in[i] && !m_line[i];
        if (c) begin m_pri[i] = cfg_prio; m_srv[i] = cfg_server; end
        if (LVL[i]) begin
          if (rh || eh) m_sent[i] = 0;
          if ((c || rs || resend) && irq_in[i] && m_pri[i] != 255 && !m_sent[i]) begin
            m_sent[i] = 1; m_req[i] = 1;
          end
        end else begin
          if (c && m_mp[i] && m_pri[i] != 255) begin m_mp[i] = 0; m_req[i] = 1; end
          if (rh) m_rej[i] = 1;
          if (rs) begin
            if (m_pri[i] == 255) m_mp[i] = 1; else m_req[i] = 1;
          end
          if (resend && m_rej[i]) begin
            m_rej[i] = 0;
            if (m_pri[i] != 255) m_req[i] = 1;
          end
        end
        m_line[i] = irq_in[i];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "model offer_valid", int'(offer_valid), int'(m_ov));
      if (m_ov) begin
        chk(phase, "model offer_num", int'(offer_num), m_num);
        chk(phase, "model offer_prio", int'(offer_prio), m_opri);
        chk(phase, "model offer_server", int'(offer_server), m_osrv);
      end
    end
  end

  task automatic cfg(int s, int sv, int p);
    cfg_we = 1; cfg_src = 3'(s); cfg_server = 4'(sv); cfg_prio = 8'(p);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic rej(int n);
    rej_valid = 1; rej_num = 12'(n); @(negedge clk); rej_valid = 0;
  endtask
  task automatic eoi(int n);
    eoi_valid = 1; eoi_num = 12'(n); @(negedge clk); eoi_valid = 0;
  endtask
  task automatic kick;
    resend = 1; @(negedge clk); resend = 0;
  endtask
  task automatic pulse(logic [N-1:0] m);
    irq_in = irq_in | m; @(negedge clk); irq_in = irq_in & ~m;
  endtask
  task automatic expect_offer(string tag, int num, int pri, int sv);
    int w = 0;
    while (!offer_valid && w < 8) begin @(negedge clk); w++; end
    chk(tag, "offer present", int'(offer_valid), 1);
    chk(tag, "offer_num", int'(offer_num), num);
    chk(tag, "offer_prio", int'(offer_prio), pri);
    chk(tag, "offer_server", int'(offer_server), sv);
    offer_ready = 1; @(negedge clk); offer_ready = 0;
  endtask
  task automatic expect_none(string tag, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, "no offer", int'(offer_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "offer_valid in reset", int'(offer_valid), 0);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    expect_none("R1", 2);
    irq_in[4] = 1;
    expect_none("R1", 3);
    irq_in[4] = 0;
    phase = "R2";
    pulse(8'h01);
    expect_none("R2", 3);
    cfg(0, 3, 5);
    expect_offer("R2", 16, 5, 3);

    phase = "R3";
    cfg(1, 2, 4);
    expect_none("R3", 3);
    pulse(8'h02);
    expect_offer("R3", 17, 4, 2);

    phase = "R4";
    cfg(4, 1, 2);
    irq_in[4] = 1;
    expect_offer("R4", 20, 2, 1);
    cfg(4, 1, 2);
    expect_none("R4", 3);

    phase = "R5";
    rej(20);
    expect_none("R5", 4);
    phase = "R6";
    kick;
    expect_offer("R6", 20, 2, 1);
    phase = "R5";
    rej(17);
    expect_none("R5", 3);
    phase = "R6";
    kick;
    expect_offer("R6", 17, 4, 2);
    expect_none("R6", 2);

    phase = "R7";
    eoi(20);
    expect_none("R7", 3);
    kick;
    expect_offer("R7", 20, 2, 1);
    eoi(16);
    kick;
    expect_none("R7", 4);

    phase = "R6";
    rej(17);
    cfg(1, 2, 255);
    kick;
    expect_none("R6", 3);
    cfg(1, 2, 4);
    expect_none("R6", 3);

    phase = "R8";
    rej(28);
    eoi(28);
    eoi(15);
    rej(12);
    kick;
    expect_none("R8", 4);
    eoi(20);
    kick;
    expect_offer("R8", 20, 2, 1);
    irq_in[4] = 0;

    phase = "R9";
    cfg(2, 0, 7);
    cfg(3, 5, 1);
    pulse(8'h0D);
    repeat (2) @(negedge clk);
    chk("R9", "first served", int'(offer_num), 16);
    repeat (3) @(negedge clk);
    chk("R9", "held under stall valid", int'(offer_valid), 1);
    chk("R9", "held under stall num", int'(offer_num), 16);
    expect_offer("R9", 16, 5, 3);
    expect_offer("R9", 18, 7, 0);
    expect_offer("R9", 19, 1, 5);
    expect_none("R9", 3);

    phase = "R1";
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    irq_in[4] = 1;
    expect_none("R1", 3);
    cfg(4, 6, 3);
    expect_offer("R1", 20, 3, 6);
    irq_in[4] = 0;
    expect_none("R1", 2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule